// File: doc/BRIEF.md
# Reload Timer with Toggling Pulse Output

The block is a down-counting interval timer made of two cascaded 8-bit stages: a prescaler and a main counter. Each stage has its own reload register. The prescaler decrements on every enabled count-source tick. Only when the prescaler passes through zero does the main counter take one step.

Each time the main counter underflows, both stages reload and keep running. On that underflow the pulse output inverts, and a one-cycle interrupt request is raised together with a sticky status flag. The count source is one of four enables:
- every clock cycle,
- every second cycle,
- every eighth cycle,
- an external slow strobe.

Software programs the timer through a small register port. A counter written while the timer is stopped is loaded at once. A counter written while the timer runs goes through a staged load paced by the count source. The control register holds:
- the start level of the pulse output, which is reapplied on every main-counter write;
- an enable for a complementary output pin.

Top module: `pulse_reload_timer`

## Requirements
- R1: After reset, pulse_out and irq are 0, pulse_inv and pulse_inv_oe are 0, and reads of all three registers return 0.
- R2: Registers: address 0 is control, with bit0 run, bits 2:1 source select, bit3 start level, bit4 complement enable and bit7 status flag (read). Address 1 returns the live prescaler count and address 2 returns the live main count. rd_data follows rd_addr combinationally.
- R3: A write to address 1 or 2 while run is 0 sets both that stage's reload value and its count, readable in the cycle after the write.
- R4: Counting starts with the first tick after run is written 1. While run is 0, both counts and pulse_out hold.
- R5: With prescaler reload n and main reload m, the main counter underflows every (n+1)(m+1) ticks. On each underflow pulse_out inverts and irq is high for exactly that one cycle.
- R6: Each underflow sets the status flag. Writing control with bit7 = 1 clears the flag, and an underflow in the same cycle wins.
- R7: A counter write while run is 1 freezes both counts for the write cycle. The first later tick captures the value into the reload register. The second tick copies it into the count. Decrementing resumes on the third tick.
- R8: Any write to address 2 forces pulse_out to the start level (control bit3) in the next cycle.
- R9: With control bit4 = 1, pulse_inv_oe is 1 and pulse_inv is the inverse of pulse_out. With bit4 = 0, both are 0.
- R10: The tick is present on every cycle for source 0, every second cycle for source 1, every eighth cycle for source 2, and on cycles with slow_strobe high for source 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 prescaler, 2 main) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| slow_strobe | input | 1 | External low-speed count enable |
| pulse_out | output | 1 | Toggling pulse output |
| pulse_inv | output | 1 | Complement of pulse_out when enabled |
| pulse_inv_oe | output | 1 | Drive enable of pulse_inv |
| irq | output | 1 | One-cycle interrupt request on underflow |

## Verification
A write takes effect at the clock edge that ends its write cycle, so its register values are due one cycle after the write task starts. During counting, underflows fall at exact tick offsets from the run write: for full-rate ticks with reloads 2 and 3, the first falls 12 cycles later. A running write shows the old count for two cycles, the new value on the third and the first decrement on the fourth. The driver pushes each expected value into a queue tagged with the exact cycle it is due, and the monitor compares it at the falling edge of that cycle. The divided count sources have no fixed phase relative to the bench, so they are checked by counting irq pulses over a 64-cycle window instead.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_DIV2 = 2'd1,
        SRC_DIV8 = 2'd2,
        SRC_SLOW = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        LD_IDLE     = 2'd0,
        LD_CAPTURE  = 2'd1,
        LD_TRANSFER = 2'd2
    } ld_phase_e;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_PRE  = 2'd1;
    localparam logic [1:0] ADDR_MAIN = 2'd2;

    // control register bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_SRC  = 1;
    localparam int CTL_POL  = 3;
    localparam int CTL_INV  = 4;
    localparam int CTL_FLAG = 7;

endpackage

// File: rtl/ptmr_tick_sel.sv
module ptmr_tick_sel
    import ptmr_pkg::*;
#(
    parameter int DIV_A = 2,
    parameter int DIV_B = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e src_i,
    input  logic     slow_i,
    output logic     tick_o
);
    localparam int CW = $clog2(DIV_B);
    localparam int AW = $clog2(DIV_A);

    logic [CW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
        unique case (src_i)
            SRC_CLK:  tick_o = 1'b1;
            SRC_DIV2: tick_o = &div_q[AW-1:0];
            SRC_DIV8: tick_o = &div_q;
            default:  tick_o = slow_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/ptmr_engine.sv
module ptmr_engine
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             wr_pre_i,
    input  logic             wr_main_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] pre_cnt_o,
    output logic [CNT_W-1:0] main_cnt_o,
    output logic             uflow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] pre_cnt;
        logic [CNT_W-1:0] pre_rld;
        logic [CNT_W-1:0] pre_stage;
        logic [CNT_W-1:0] main_cnt;
        logic [CNT_W-1:0] main_rld;
        logic [CNT_W-1:0] main_stage;
        logic [1:0]       pend;       // bit0 prescaler, bit1 main
        ld_phase_e        phase;
    } eng_s;

    eng_s eng_d, eng_q;
    logic adv;

    always_comb begin
        eng_d   = eng_q;
        uflow_o = 1'b0;
        adv     = run_i && tick_i;
        if (!run_i) begin
            // stopped: direct load of reload and count
            if (wr_pre_i) begin
                eng_d.pre_rld = wr_data_i;
                eng_d.pre_cnt = wr_data_i;
            end
            if (wr_main_i) begin
                eng_d.main_rld = wr_data_i;
                eng_d.main_cnt = wr_data_i;
            end
        end else if (wr_pre_i || wr_main_i) begin
            // running: stage data, restart the load sequence
            if (wr_pre_i)  eng_d.pre_stage  = wr_data_i;
            if (wr_main_i) eng_d.main_stage = wr_data_i;
            eng_d.pend  = eng_q.pend | {wr_main_i, wr_pre_i};
            eng_d.phase = LD_CAPTURE;
        end else if (adv) begin
            unique case (eng_q.phase)
                LD_CAPTURE: begin
                    if (eng_q.pend[0]) eng_d.pre_rld  = eng_q.pre_stage;
                    if (eng_q.pend[1]) eng_d.main_rld = eng_q.main_stage;
                    eng_d.phase = LD_TRANSFER;
                end
                LD_TRANSFER: begin
                    if (eng_q.pend[0]) eng_d.pre_cnt  = eng_q.pre_rld;
                    if (eng_q.pend[1]) eng_d.main_cnt = eng_q.main_rld;
                    eng_d.pend  = '0;
                    eng_d.phase = LD_IDLE;
                end
                default: begin
                    if (eng_q.pre_cnt == '0) begin
                        eng_d.pre_cnt = eng_q.pre_rld;
                        if (eng_q.main_cnt == '0) begin
                            eng_d.main_cnt = eng_q.main_rld;
                            uflow_o        = 1'b1;
                        end else begin
                            eng_d.main_cnt = eng_q.main_cnt - 1'b1;
                        end
                    end else begin
                        eng_d.pre_cnt = eng_q.pre_cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign pre_cnt_o  = eng_q.pre_cnt;
    assign main_cnt_o = eng_q.main_cnt;

endmodule

// File: rtl/pulse_reload_timer.sv
module pulse_reload_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_A = 2,
    parameter int DIV_B = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             slow_strobe,
    output logic             pulse_out,
    output logic             pulse_inv,
    output logic             pulse_inv_oe,
    output logic             irq
);
    typedef struct packed {
        logic     run;
        src_sel_e src;
        logic     pol;
        logic     inv_en;
        logic     flag;
        logic     out;
        logic     irq;
    } ctl_s;

    ctl_s st_d, st_q;

    logic             wr_ctl, wr_pre, wr_main;
    logic             tick, uflow;
    logic [CNT_W-1:0] pre_cnt, main_cnt;
    logic             unused_wr_bits;

    assign wr_ctl  = wr_en && (wr_addr == ADDR_CTL);
    assign wr_pre  = wr_en && (wr_addr == ADDR_PRE);
    assign wr_main = wr_en && (wr_addr == ADDR_MAIN);
    assign unused_wr_bits = ^wr_data[CNT_W-1:5];

    ptmr_tick_sel #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (st_q.src),
        .slow_i (slow_strobe),
        .tick_o (tick)
    );

    ptmr_engine #(
        .CNT_W (CNT_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.run),
        .tick_i     (tick),
        .wr_pre_i   (wr_pre),
        .wr_main_i  (wr_main),
        .wr_data_i  (wr_data),
        .pre_cnt_o  (pre_cnt),
        .main_cnt_o (main_cnt),
        .uflow_o    (uflow)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_ctl) begin
            st_d.run    = wr_data[CTL_RUN];
            st_d.src    = src_sel_e'(wr_data[CTL_SRC +: 2]);
            st_d.pol    = wr_data[CTL_POL];
            st_d.inv_en = wr_data[CTL_INV];
            if (wr_data[CTL_FLAG]) st_d.flag = 1'b0;
        end
        if (uflow) begin
            st_d.out  = ~st_q.out;
            st_d.irq  = 1'b1;
            st_d.flag = 1'b1;
        end
        if (wr_main) st_d.out = st_q.pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTL: begin
                rd_data[CTL_RUN]      = st_q.run;
                rd_data[CTL_SRC +: 2] = st_q.src;
                rd_data[CTL_POL]      = st_q.pol;
                rd_data[CTL_INV]      = st_q.inv_en;
                rd_data[CTL_FLAG]     = st_q.flag;
            end
            ADDR_PRE:  rd_data = pre_cnt;
            ADDR_MAIN: rd_data = main_cnt;
            default:   rd_data = '0;
        endcase
    end

    assign pulse_out    = st_q.out;
    assign pulse_inv_oe = st_q.inv_en;
    assign pulse_inv    = st_q.inv_en & ~st_q.out;
    assign irq          = st_q.irq;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             run,
    input logic             pol,
    input logic             flag,
    input logic             uflow,
    input logic             pulse_out,
    input logic             irq,
    input logic [CNT_W-1:0] pre_cnt,
    input logic [CNT_W-1:0] main_cnt
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr == ADDR_PRE || wr_addr == ADDR_MAIN);

    // R5: an underflow inverts the pulse output on the next edge
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> pulse_out != $past(pulse_out));

    // R5: irq only follows an engine underflow
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(uflow));

    // R6: the status flag is up whenever irq is
    a_r6_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R4: stopped and unwritten counters hold
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> ($stable(pre_cnt) && $stable(main_cnt)));

    // R7: a running counter write freezes the counts for its cycle
    a_r7_write_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_wr) |=> ($stable(pre_cnt) && $stable(main_cnt)));

    // R8: main counter write restores the start level
    a_r8_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MAIN) |=> pulse_out == $past(pol));

endmodule

bind pulse_reload_timer ptmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .run       (st_q.run),
    .pol       (st_q.pol),
    .flag      (st_q.flag),
    .uflow     (uflow),
    .pulse_out (pulse_out),
    .irq       (irq),
    .pre_cnt   (pre_cnt),
    .main_cnt  (main_cnt)
);

// File: tb/pulse_reload_timer_tb.sv
module pulse_reload_timer_tb;
    import ptmr_pkg::*;

    localparam int W = 8;
    localparam int K_OUT = 0, K_IRQ = 1, K_RD = 2, K_INV = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         slow_strobe = 1'b0;
    logic         pulse_out, pulse_inv, pulse_inv_oe, irq;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    typedef struct {
        int       due;
        int       kind;
        logic [1:0] addr;
        int       val;
        string    tag;
    } exp_t;

    exp_t sb[$];

    pulse_reload_timer #(.CNT_W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .slow_strobe  (slow_strobe),
        .pulse_out    (pulse_out),
        .pulse_inv    (pulse_inv),
        .pulse_inv_oe (pulse_inv_oe),
        .irq          (irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, string what, int act, int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    task automatic expect_at(int d, int kind, logic [1:0] a, int v, string tag);
        exp_t e;
        e.due = cyc + d; e.kind = kind; e.addr = a; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop due items and compare
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                it = sb.pop_front();
                if (it.due < cyc) chk(it.tag, "late item", it.due, cyc);
                case (it.kind)
                    K_OUT: chk(it.tag, "pulse_out", int'(pulse_out), it.val);
                    K_IRQ: chk(it.tag, "irq", int'(irq), it.val);
                    K_INV: chk(it.tag, "{pulse_inv_oe,pulse_inv}",
                               int'({pulse_inv_oe, pulse_inv}), it.val);
                    default: begin
                        rd_addr = it.addr;
                        #1;
                        chk(it.tag, $sformatf("rd[%0d]", it.addr), int'(rd_data), it.val);
                    end
                endcase
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // driver
    initial begin
        int n;
        int expn[3];
        expn[0] = 64; expn[1] = 32; expn[2] = 8;

        wait_cycles(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(0, K_OUT, 0, 0, "R1");
        expect_at(0, K_IRQ, 0, 0, "R1");
        expect_at(0, K_INV, 0, 0, "R1");
        expect_at(0, K_RD, ADDR_CTL, 0, "R1");
        expect_at(0, K_RD, ADDR_PRE, 0, "R1");
        expect_at(0, K_RD, ADDR_MAIN, 0, "R1");
        wait_cycles(1);

        // R3 stopped loads
        wr(ADDR_PRE, 8'd2);
        expect_at(0, K_RD, ADDR_PRE, 2, "R3");
        wr(ADDR_MAIN, 8'd3);
        expect_at(0, K_RD, ADDR_MAIN, 3, "R3");

        // R5 period (2+1)*(3+1)=12, toggle and one-cycle irq
        wr(ADDR_CTL, 8'h01);
        expect_at(1, K_RD, ADDR_PRE, 1, "R4");
        expect_at(3, K_RD, ADDR_MAIN, 2, "R5");
        expect_at(11, K_OUT, 0, 0, "R5");
        expect_at(12, K_OUT, 0, 1, "R5");
        expect_at(12, K_IRQ, 0, 1, "R5");
        expect_at(13, K_IRQ, 0, 0, "R5");
        expect_at(13, K_RD, ADDR_CTL, 8'h81, "R6");
        expect_at(24, K_OUT, 0, 0, "R5");
        expect_at(24, K_IRQ, 0, 1, "R5");
        wait_cycles(25);
        wr(ADDR_CTL, 8'h81);
        expect_at(0, K_RD, ADDR_CTL, 8'h01, "R6");

        // R4 stop and hold
        wr(ADDR_CTL, 8'h00);
        expect_at(0, K_RD, ADDR_PRE, 2, "R4");
        expect_at(0, K_RD, ADDR_MAIN, 2, "R4");
        expect_at(8, K_RD, ADDR_PRE, 2, "R4");
        expect_at(8, K_RD, ADDR_MAIN, 2, "R4");
        expect_at(8, K_OUT, 0, 0, "R4");
        wait_cycles(8);

        // R7/R8 running write of main counter
        wr(ADDR_PRE, 8'd0);
        wr(ADDR_MAIN, 8'd2);
        wr(ADDR_CTL, 8'h01);
        expect_at(3, K_OUT, 0, 1, "R5");
        expect_at(3, K_RD, ADDR_MAIN, 2, "R5");
        wait_cycles(3);
        wr(ADDR_MAIN, 8'd5);
        expect_at(0, K_OUT, 0, 0, "R8");
        expect_at(0, K_RD, ADDR_MAIN, 2, "R7");
        expect_at(1, K_RD, ADDR_MAIN, 2, "R7");
        expect_at(2, K_RD, ADDR_MAIN, 5, "R7");
        expect_at(3, K_RD, ADDR_MAIN, 4, "R7");
        wait_cycles(4);

        // R7 running write of prescaler
        wr(ADDR_PRE, 8'd1);
        expect_at(1, K_RD, ADDR_MAIN, 3, "R7");
        expect_at(1, K_RD, ADDR_PRE, 0, "R7");
        expect_at(2, K_RD, ADDR_PRE, 1, "R7");
        expect_at(3, K_RD, ADDR_PRE, 0, "R7");
        expect_at(3, K_RD, ADDR_MAIN, 3, "R7");
        expect_at(4, K_RD, ADDR_MAIN, 2, "R7");
        wait_cycles(5);
        wr(ADDR_CTL, 8'h00);

        // R8/R9/R2 polarity and complement output
        wr(ADDR_CTL, 8'h08);
        wr(ADDR_MAIN, 8'd7);
        expect_at(0, K_OUT, 0, 1, "R8");
        wr(ADDR_CTL, 8'h18);
        expect_at(0, K_INV, 0, 2, "R9");
        expect_at(0, K_RD, ADDR_CTL, 8'h98, "R2");
        wr(ADDR_CTL, 8'h08);
        expect_at(0, K_INV, 0, 0, "R9");
        wait_cycles(1);
        while (sb.size() != 0) @(negedge clk);

        // R10 count sources: reloads 0 so every tick underflows
        wr(ADDR_CTL, 8'h00);
        wr(ADDR_PRE, 8'd0);
        wr(ADDR_MAIN, 8'd0);
        for (int s = 0; s < 3; s++) begin
            n = 0;
            wr(ADDR_CTL, W'((s << 1) | 1));
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (irq) n++;
            end
            chk("R10", $sformatf("irq count src %0d", s), n, expn[s]);
            wr(ADDR_CTL, 8'h00);
            wait_cycles(2);
        end
        n = 0;
        wr(ADDR_CTL, 8'h07);
        for (int i = 0; i < 40; i++) begin
            slow_strobe = (i % 8 == 0);
            @(negedge clk);
            if (irq) n++;
        end
        slow_strobe = 1'b0;
        chk("R10", "irq count slow strobe", n, 5);
        wr(ADDR_CTL, 8'h00);

        wait_cycles(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule